// File: doc/BRIEF.md
# Ternary Packet Rule Classifier

This block sorts packets into flows by matching a lookup key against a small table of ternary rules. The key joins the five header fields of a packet (source and destination address, source and destination port, protocol) with a vector of payload-category flags produced upstream by a content scanner. Every rule row holds a value word and a care mask over the whole key, a flow identifier, a drop action and a valid bit. All rows are compared with the key in the same cycle. The lowest-numbered matching row decides the result.

A host loads rows one at a time through a simple write port. A lookup is a single-cycle strobe with the key fields. One cycle later the block presents a registered result: whether any row hit, whether the packet is to be discarded, and the flow identifier. Because the content flags sit inside the key, a rule can discard every packet that a scanner flagged for a given category, whatever its headers. When nothing matches, the packet is passed with a default flow identifier supplied by the host.

Top module: `tcam_flow_classifier`

## Requirements
- R1: After synchronous reset, res_valid, res_hit, res_drop and res_flow are 0 and every row is invalid, so the first lookup misses.
- R2: res_valid is 1 in exactly the cycle after a cycle with lk_req high, and 0 otherwise.
- R3: The key is {lk_src_ip[111:80], lk_dst_ip[79:48], lk_src_port[47:32], lk_dst_port[31:16], lk_proto[15:8], lk_content[7:0]}; a valid row hits when, for every bit where its mask is 1, key and value are equal (mask 0 bits are ignored).
- R4: When several rows hit, the row with the lowest index supplies res_flow and res_drop.
- R5: On a hit, res_hit is 1, res_drop equals the winning row's drop bit and res_flow its flow identifier; res_drop is never 1 without res_hit.
- R6: On a miss, res_hit is 0, res_drop is 0 and res_flow equals dflt_flow as sampled in the lookup cycle.
- R7: A row write in the same cycle as a lookup is not seen by that lookup; it is seen by every later lookup.
- R8: A row written with wr_valid 0 never hits, whatever its value and mask.
- R9: A rule that cares only about one content bit (key bits [7:0]) with its drop bit set discards exactly those packets whose content vector has that bit set.
- R10: In cycles without a result (res_valid 0), res_hit, res_drop and res_flow keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one rule row |
| wr_row | input | 4 | Row index to write |
| wr_value | input | 112 | Rule value word |
| wr_mask | input | 112 | Rule care mask (1 = compare) |
| wr_flow | input | 12 | Flow identifier of the rule |
| wr_drop | input | 1 | Rule discards matching packets |
| wr_valid | input | 1 | Row enabled |
| dflt_flow | input | 12 | Flow identifier returned on a miss |
| lk_req | input | 1 | Lookup strobe |
| lk_src_ip | input | 32 | Source address |
| lk_dst_ip | input | 32 | Destination address |
| lk_src_port | input | 16 | Source port |
| lk_dst_port | input | 16 | Destination port |
| lk_proto | input | 8 | Protocol number |
| lk_content | input | 8 | Payload category flags |
| res_valid | output | 1 | Result present this cycle |
| res_hit | output | 1 | Some row matched |
| res_drop | output | 1 | Packet is to be discarded |
| res_flow | output | 12 | Assigned flow identifier |

## Verification
The assertions assume reset is held for at least two clock cycles before the first lookup, and that wr_row addresses a row that exists; the bench only drives row indices below the table depth and holds reset for four cycles. They also assume dflt_flow and the key are steady across the lookup cycle, which the bench ensures by changing inputs only on the falling clock edge. Sweeps cover every key bit position as a sole care bit, all 256 content vectors against a content rule, and filling and emptying the table row by row to walk the priority order.

// File: rtl/tcls_pkg.sv
package tcls_pkg;
  // Fixed header field widths of the lookup key
  localparam int IP_W    = 32;
  localparam int PORT_W  = 16;
  localparam int PROTO_W = 8;
  localparam int HDR_W   = 2 * IP_W + 2 * PORT_W + PROTO_W;
endpackage

// File: rtl/tcls_rule_store.sv
// Rule table storage: one row written per cycle, all rows readable at once.
module tcls_rule_store #(
  parameter int NUM_ROWS = 16,
  parameter int KEY_W    = 112,
  parameter int FLOW_W   = 12,
  localparam int ROW_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [KEY_W-1:0]  wr_value,
  input  logic [KEY_W-1:0]  wr_mask,
  input  logic [FLOW_W-1:0] wr_flow,
  input  logic              wr_drop,
  input  logic              wr_valid,
  output logic [KEY_W-1:0]  row_value [NUM_ROWS],
  output logic [KEY_W-1:0]  row_mask  [NUM_ROWS],
  output logic [FLOW_W-1:0] row_flow  [NUM_ROWS],
  output logic [NUM_ROWS-1:0] row_drop,
  output logic [NUM_ROWS-1:0] row_valid
);

  logic [KEY_W-1:0]    value_q [NUM_ROWS];
  logic [KEY_W-1:0]    mask_q  [NUM_ROWS];
  logic [FLOW_W-1:0]   flow_q  [NUM_ROWS];
  logic [NUM_ROWS-1:0] drop_q;
  logic [NUM_ROWS-1:0] valid_q;

  // Data words carry no reset; only the enable bits are cleared.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      value_q[wr_row] <= wr_value;
      mask_q[wr_row]  <= wr_mask;
      flow_q[wr_row]  <= wr_flow;
      drop_q[wr_row]  <= wr_drop;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_row] <= wr_valid;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_ROWS; i++) begin
      row_value[i] = value_q[i];
      row_mask[i]  = mask_q[i];
      row_flow[i]  = flow_q[i];
    end
    row_drop  = drop_q;
    row_valid = valid_q;
  end

endmodule

// File: rtl/tcls_row_cmp.sv
// Ternary compare of one row against the key.
module tcls_row_cmp #(
  parameter int KEY_W = 112
) (
  input  logic [KEY_W-1:0] key,
  input  logic [KEY_W-1:0] value,
  input  logic [KEY_W-1:0] mask,
  input  logic             valid,
  output logic             hit
);

  logic [KEY_W-1:0] diff;

  always_comb begin
    diff = (key ^ value) & mask;
    hit  = valid && (diff == '0);
  end

endmodule

// File: rtl/tcls_prio_pick.sv
// Lowest-index-wins selection over the row hit vector.
module tcls_prio_pick #(
  parameter int NUM_ROWS = 16,
  localparam int ROW_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic [NUM_ROWS-1:0] req,
  output logic [NUM_ROWS-1:0] grant,
  output logic [ROW_W-1:0]    idx,
  output logic                any
);

  // One-hot grant: isolate the lowest set bit.
  always_comb begin
    grant = req & (~req + NUM_ROWS'(1));
  end

  // Encoded index: scan from the top so the lowest hit is left last.
  always_comb begin
    idx = '0;
    for (int i = NUM_ROWS - 1; i >= 0; i--) begin
      if (req[i]) idx = ROW_W'(i);
    end
    any = |req;
  end

endmodule

// File: rtl/tcam_flow_classifier.sv
module tcam_flow_classifier
  import tcls_pkg::*;
#(
  parameter int NUM_ROWS  = 16,
  parameter int FLOW_W    = 12,
  parameter int CONTENT_W = 8,
  localparam int KEY_W    = HDR_W + CONTENT_W,
  localparam int ROW_W    = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ROW_W-1:0]   wr_row,
  input  logic [KEY_W-1:0]   wr_value,
  input  logic [KEY_W-1:0]   wr_mask,
  input  logic [FLOW_W-1:0]  wr_flow,
  input  logic               wr_drop,
  input  logic               wr_valid,
  input  logic [FLOW_W-1:0]  dflt_flow,
  input  logic               lk_req,
  input  logic [IP_W-1:0]    lk_src_ip,
  input  logic [IP_W-1:0]    lk_dst_ip,
  input  logic [PORT_W-1:0]  lk_src_port,
  input  logic [PORT_W-1:0]  lk_dst_port,
  input  logic [PROTO_W-1:0] lk_proto,
  input  logic [CONTENT_W-1:0] lk_content,
  output logic               res_valid,
  output logic               res_hit,
  output logic               res_drop,
  output logic [FLOW_W-1:0]  res_flow
);

  logic [KEY_W-1:0]    key;
  logic [KEY_W-1:0]    row_value [NUM_ROWS];
  logic [KEY_W-1:0]    row_mask  [NUM_ROWS];
  logic [FLOW_W-1:0]   row_flow  [NUM_ROWS];
  logic [NUM_ROWS-1:0] row_drop;
  logic [NUM_ROWS-1:0] row_valid;
  logic [NUM_ROWS-1:0] row_hit;
  logic [NUM_ROWS-1:0] win_onehot;
  logic [ROW_W-1:0]    win_idx;
  logic                win_any;

  // Header fields high, content flags in the low bits.
  assign key = {lk_src_ip, lk_dst_ip, lk_src_port, lk_dst_port, lk_proto, lk_content};

  tcls_rule_store #(
    .NUM_ROWS(NUM_ROWS),
    .KEY_W   (KEY_W),
    .FLOW_W  (FLOW_W)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_row   (wr_row),
    .wr_value (wr_value),
    .wr_mask  (wr_mask),
    .wr_flow  (wr_flow),
    .wr_drop  (wr_drop),
    .wr_valid (wr_valid),
    .row_value(row_value),
    .row_mask (row_mask),
    .row_flow (row_flow),
    .row_drop (row_drop),
    .row_valid(row_valid)
  );

  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
    tcls_row_cmp #(.KEY_W(KEY_W)) u_cmp (
      .key  (key),
      .value(row_value[g]),
      .mask (row_mask[g]),
      .valid(row_valid[g]),
      .hit  (row_hit[g])
    );
  end

  tcls_prio_pick #(.NUM_ROWS(NUM_ROWS)) u_pick (
    .req  (row_hit),
    .grant(win_onehot),
    .idx  (win_idx),
    .any  (win_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_drop  <= 1'b0;
      res_flow  <= '0;
    end else begin
      res_valid <= lk_req;
      if (lk_req) begin
        res_hit  <= win_any;
        res_drop <= win_any && row_drop[win_idx];
        res_flow <= win_any ? row_flow[win_idx] : dflt_flow;
      end
    end
  end

endmodule

// File: rtl/tcls_checker.sv
module tcls_checker #(
  parameter int NUM_ROWS = 16,
  parameter int FLOW_W   = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_req,
  input logic [FLOW_W-1:0] dflt_flow,
  input logic              res_valid,
  input logic              res_hit,
  input logic              res_drop,
  input logic [FLOW_W-1:0] res_flow,
  input logic [NUM_ROWS-1:0] win_onehot
);

  AST_RESULT_AFTER_REQ: assert property (@(posedge clk) disable iff (rst) lk_req |=> res_valid); // R2
  AST_NO_RESULT_IDLE: assert property (@(posedge clk) disable iff (rst) !lk_req |=> !res_valid); // R2
  AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (rst) $onehot0(win_onehot)); // R4
  AST_HIT_HAS_WINNER: assert property (@(posedge clk) disable iff (rst) lk_req |=> (res_hit == ($countones($past(win_onehot)) == 1))); // R4
  AST_DROP_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst) res_drop |-> res_hit); // R5
  AST_MISS_DEFAULT: assert property (@(posedge clk) disable iff (rst) lk_req |=> (res_hit || res_flow == $past(dflt_flow))); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !res_valid |-> ($stable(res_hit) && $stable(res_drop) && $stable(res_flow))); // R10

endmodule

bind tcam_flow_classifier tcls_checker #(
  .NUM_ROWS(NUM_ROWS),
  .FLOW_W  (FLOW_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lk_req    (lk_req),
  .dflt_flow (dflt_flow),
  .res_valid (res_valid),
  .res_hit   (res_hit),
  .res_drop  (res_drop),
  .res_flow  (res_flow),
  .win_onehot(win_onehot)
);

// File: tb/tcam_flow_classifier_test.sv
`timescale 1ns/1ps
module tcam_flow_classifier_test;
  localparam int N   = 16;
  localparam int FW  = 12;
  localparam int KW  = 112;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [3:0] wr_row = '0;
  logic [KW-1:0] wr_value = '0, wr_mask = '0;
  logic [FW-1:0] wr_flow = '0;
  logic wr_drop = 1'b0, wr_valid = 1'b0;
  logic [FW-1:0] dflt_flow = '0;
  logic lk_req = 1'b0;
  logic [KW-1:0] lk_key = '0;
  logic res_valid, res_hit, res_drop;
  logic [FW-1:0] res_flow;

  always #2.5 clk = ~clk;

  tcam_flow_classifier uut (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_row(wr_row), .wr_value(wr_value), .wr_mask(wr_mask),
    .wr_flow(wr_flow), .wr_drop(wr_drop), .wr_valid(wr_valid),
    .dflt_flow(dflt_flow), .lk_req(lk_req),
    .lk_src_ip(lk_key[111:80]), .lk_dst_ip(lk_key[79:48]),
    .lk_src_port(lk_key[47:32]), .lk_dst_port(lk_key[31:16]),
    .lk_proto(lk_key[15:8]), .lk_content(lk_key[7:0]),
    .res_valid(res_valid), .res_hit(res_hit), .res_drop(res_drop), .res_flow(res_flow)
  );

  // Bench-side rule model
  logic [KW-1:0] m_val [N];
  logic [KW-1:0] m_msk [N];
  logic [FW-1:0] m_flow [N];
  logic [N-1:0]  m_drop = '0;
  logic [N-1:0]  m_vld = '0;
  logic [KW-1:0] saved [N];

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5679;

  function automatic logic [31:0] step(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    return x;
  endfunction

  task automatic rnd_key(output logic [KW-1:0] k);
    logic [127:0] w;
    for (int i = 0; i < 4; i++) begin
      seed = step(seed);
      w[i*32 +: 32] = seed;
    end
    k = w[KW-1:0];
  endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic predict(input logic [KW-1:0] k, input logic [FW-1:0] d,
                         output logic eh, output logic ed, output logic [FW-1:0] ef);
    eh = 0; ed = 0; ef = d;
    for (int i = N - 1; i >= 0; i--) begin
      if (m_vld[i] && (((k ^ m_val[i]) & m_msk[i]) == '0)) begin
        eh = 1; ed = m_drop[i]; ef = m_flow[i];
      end
    end
  endtask

  task automatic write_row(input int r, input logic [KW-1:0] v, input logic [KW-1:0] m,
                           input logic [FW-1:0] f, input logic dr, input logic vl);
    @(negedge clk);
    wr_en = 1; wr_row = 4'(r); wr_value = v; wr_mask = m;
    wr_flow = f; wr_drop = dr; wr_valid = vl;
    @(negedge clk);
    wr_en = 0;
    m_val[r] = v; m_msk[r] = m; m_flow[r] = f; m_drop[r] = dr; m_vld[r] = vl;
  endtask

  task automatic lookup(input logic [KW-1:0] k, input logic [FW-1:0] d, input string r);
    logic eh, ed;
    logic [FW-1:0] ef;
    predict(k, d, eh, ed, ef);
    @(negedge clk);
    lk_req = 1; lk_key = k; dflt_flow = d;
    @(negedge clk);
    lk_req = 0;
    chk("R2 valid", 32'(res_valid), 32'd1);
    chk({r, " hit"}, 32'(res_hit), 32'(eh));
    chk({r, " drop"}, 32'(res_drop), 32'(ed));
    chk({r, " flow"}, 32'(res_flow), 32'(ef));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [KW-1:0] k;
    logic [FW-1:0] hold_flow;
    logic hold_hit, hold_drop;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1 valid", 32'(res_valid), 0);
    chk("R1 hit", 32'(res_hit), 0);
    chk("R1 drop", 32'(res_drop), 0);
    chk("R1 flow", 32'(res_flow), 0);
    rnd_key(k);
    lookup(k, 12'h5A5, "R1 empty");

    // R3/R5: exact-match rows
    for (int r = 0; r < N; r++) begin
      rnd_key(k);
      saved[r] = k;
      write_row(r, k, '1, FW'(100 + r), (r % 5) == 0, 1'b1);
    end
    for (int r = 0; r < N; r++) lookup(saved[r], 12'h111, "R3 exact R5");
    rnd_key(k);
    lookup(k, 12'h3C3, "R6 miss");

    // R4: wildcard rows added from the bottom up; lowest index wins
    for (int n = N - 1; n >= 0; n--) begin
      write_row(n, '0, '0, FW'(12'h200 + n), (n % 3) == 0, 1'b1);
      rnd_key(k);
      lookup(k, 12'h0F0, "R4 prio");
    end

    // R8: disable rows one by one
    for (int n = 0; n < N; n++) begin
      write_row(n, '0, '0, FW'(12'h300 + n), 1'b0, 1'b0);
      rnd_key(k);
      lookup(k, 12'h0E1, "R8 invalid");
    end

    // R3: every key bit as the sole care bit
    for (int j = 0; j < KW; j++) begin
      write_row(0, KW'(1) << j, KW'(1) << j, FW'(j), 1'b0, 1'b1);
      rnd_key(k);
      lookup(k | (KW'(1) << j), 12'h0AB, "R3 bit set");
      lookup(k & ~(KW'(1) << j), 12'h0AC, "R3 bit clear");
    end

    // R9: content category rule over all content vectors
    write_row(0, KW'(4), KW'(4), 12'h7FF, 1'b1, 1'b1);
    write_row(1, '0, '0, 12'h0AA, 1'b0, 1'b1);
    for (int c = 0; c < 256; c++) begin
      rnd_key(k);
      k[7:0] = 8'(c);
      lookup(k, 12'h001, "R9 content");
    end

    // R7: write and lookup in the same cycle
    @(negedge clk);
    wr_en = 1; wr_row = 0; wr_value = '0; wr_mask = '0; wr_flow = 12'h123;
    wr_drop = 0; wr_valid = 1;
    lk_req = 1; lk_key = '0; lk_key[7:0] = 8'h04; dflt_flow = 12'h002;
    @(negedge clk);
    wr_en = 0; lk_req = 0;
    chk("R7 old hit", 32'(res_hit), 1);
    chk("R7 old drop", 32'(res_drop), 1);
    chk("R7 old flow", 32'(res_flow), 32'h7FF);
    m_val[0] = '0; m_msk[0] = '0; m_flow[0] = 12'h123; m_drop[0] = 0; m_vld[0] = 1;
    lk_key[7:0] = 8'h04;
    lookup(lk_key, 12'h002, "R7 new");

    // R10: outputs hold without a lookup
    hold_hit = res_hit; hold_drop = res_drop; hold_flow = res_flow;
    for (int t = 0; t < 3; t++) begin
      rnd_key(k);
      lk_key = k; dflt_flow = FW'(t + 9);
      @(negedge clk);
      chk("R2 idle", 32'(res_valid), 0);
      chk("R10 hit", 32'(res_hit), 32'(hold_hit));
      chk("R10 drop", 32'(res_drop), 32'(hold_drop));
      chk("R10 flow", 32'(res_flow), 32'(hold_flow));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule